// File: doc/BRIEF.md
# Packed Saturating Doubling Multiply-High Unit

This block works on packed vectors of signed integers. A 2-bit size code divides each vector into lanes of 8, 16, 32 or 64 bits. In every lane the two signed operands are multiplied and the product is doubled. The lane keeps the upper half of the doubled product and clamps it to the signed range of the lane. Every lane that clamps raises its own flag. A sticky flag collects these flags across results and holds them until software-independent logic clears it.

Vectors are processed in groups. A start pulse begins a group of two or four first-operand vectors, and all of them share one second-operand vector. The unit takes one first-operand vector per cycle. It shows on `vecIdx` which vector it expects next. Each result appears one cycle later, tagged with its vector index, so the surrounding logic can write it back over the operand it came from. A done pulse marks the last result of the group.

Top module: `sdmhUnit`

## Requirements
- R1: `sizeSel` picks the lane width N = 8 << sizeSel (0→8, 1→16, 2→32, 3→64). Lane i occupies bits [i*N +: N] of `opA`, `opB` and `result`, and there are W/N lanes.
- R2: For every lane whose operands are not both the lane minimum, the result lane equals floor(2·a·b / 2^N), with a and b read as signed two's-complement values.
- R3: When both operands of a lane equal the lane minimum −2^(N−1), the result lane is 2^(N−1)−1 and `laneSat[i]` is 1. `laneSat` bits at positions W/N and above are 0.
- R4: Every lane whose operands are not both the minimum has `laneSat[i]` equal to 0. This includes min×max, zero and −1.
- R5: After a start pulse while idle, the unit processes 2 vectors (`groupCount`=0) or 4 vectors (`groupCount`=1), one per cycle. `vecIdx` counts 0,1,… to name the vector that must be on `opA`. The result for that vector appears on the next cycle with `resValid`=1 and `resIdx` equal to its index.
- R6: `done` is 1 exactly in the cycle that carries the last result of a group and is 0 at all other times.
- R7: A start pulse while a group is in progress has no effect. The group keeps its length, and no further results follow it.
- R8: `stickySat` becomes 1 with any result that has a `laneSat` bit set. It then holds until a cycle in which `satClear` is 1. The cleared value is visible on the next cycle, and a clear wins over saturation in the same cycle.
- R9: After reset, `resValid`, `done` and `stickySat` are 0 and `vecIdx` is 0.
- R10: `resValid` is 0 in every cycle that does not follow a processing cycle.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a group when idle |
| groupCount | input | 1 | 0: two vectors, 1: four vectors |
| sizeSel | input | 2 | Lane width code |
| opA | input | W | First-operand vector for index `vecIdx` |
| opB | input | W | Shared second-operand vector |
| satClear | input | 1 | Clears the sticky flag |
| vecIdx | output | 2 | Index of the vector expected on `opA` |
| busy | output | 1 | Group in progress |
| result | output | W | Lane results |
| laneSat | output | W/8 | Per-lane saturation flags |
| resValid | output | 1 | `result` holds a new vector |
| resIdx | output | 2 | Vector index of `result` |
| done | output | 1 | Last result of the group |
| stickySat | output | 1 | Accumulated saturation |

## Verification
At each of the four lane widths, a shared operand filled with the lane minimum is paired with vectors of minimum, maximum, zero and −1. This separates the single clamping case from min×max, which looks close to it but must not clamp, and it also checks sign handling and the rounding toward minus infinity of −1 products. Groups with random data check lane placement and the lane-width selection. Further runs place a start pulse in the middle of a group, and assert a clear in the same cycle as a clamping result and while the unit is idle. These separate ignoring a restart from restarting, and clear-priority from set-priority on the sticky flag.

// File: rtl/sdmhPkg.sv
package sdmhPkg;
  typedef struct packed {
    logic       issue;
    logic       last;
    logic [1:0] idx;
  } sdmhStrobe_t;
endpackage

// File: rtl/sdmhCtrl.sv
module sdmhCtrl
  import sdmhPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        groupCount,
  output sdmhStrobe_t strobe,
  output logic [1:0]  vecIdx,
  output logic        busy
);
  logic [1:0] idxQ;
  logic [1:0] lastIdxQ;
  logic       busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      idxQ     <= '0;
      lastIdxQ <= '0;
    end else if (!busyQ) begin
      if (start) begin
        busyQ    <= 1'b1;
        idxQ     <= '0;
        lastIdxQ <= groupCount ? 2'd3 : 2'd1;
      end
    end else begin
      if (idxQ == lastIdxQ) begin
        busyQ <= 1'b0;
        idxQ  <= '0;
      end else begin
        idxQ <= idxQ + 2'd1;
      end
    end
  end

  always_comb begin
    strobe.issue = busyQ;
    strobe.last  = busyQ && (idxQ == lastIdxQ);
    strobe.idx   = idxQ;
  end

  assign vecIdx = idxQ;
  assign busy   = busyQ;

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && idxQ == lastIdxQ) |=> !busyQ); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && idxQ != lastIdxQ) |=> (busyQ && idxQ == $past(idxQ) + 2'd1)); // R7
endmodule

// File: rtl/sdmhLanes.sv
module sdmhLanes
  import sdmhPkg::*;
#(
  parameter int W = 128
) (
  input  logic          clk,
  input  logic          rstN,
  input  sdmhStrobe_t   strobe,
  input  logic [1:0]    sizeSel,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic          satClear,
  output logic [W-1:0]  result,
  output logic [W/8-1:0] laneSat,
  output logic          resValid,
  output logic [1:0]    resIdx,
  output logic          done,
  output logic          stickySat
);
  localparam int MAXL = W / 8;

  for (genvar s = 0; s < 4; s++) begin : gSize
    localparam int N = 8 << s;
    localparam int L = W / N;
    localparam logic [N-1:0] MINV = {1'b1, {(N-1){1'b0}}};
    localparam logic [N-1:0] MAXV = {1'b0, {(N-1){1'b1}}};
    logic [W-1:0]    res;
    logic [MAXL-1:0] sat;
    for (genvar l = 0; l < L; l++) begin : gLane
      logic [N-1:0]          a;
      logic [N-1:0]          b;
      logic signed [2*N-1:0] prod;
      logic                  bothMin;
      assign a       = opA[l*N +: N];
      assign b       = opB[l*N +: N];
      assign prod    = $signed({{N{a[N-1]}}, a}) * $signed({{N{b[N-1]}}, b});
      assign bothMin = (a == MINV) && (b == MINV);
      assign res[l*N +: N] = bothMin ? MAXV : prod[2*N-2:N-1];
      assign sat[l]  = bothMin;
    end
    if (L < MAXL) begin : gPad
      assign sat[MAXL-1:L] = '0;
    end
  end

  logic [W-1:0]    resC;
  logic [MAXL-1:0] satC;

  always_comb begin
    unique case (sizeSel)
      2'd0: begin resC = gSize[0].res; satC = gSize[0].sat; end
      2'd1: begin resC = gSize[1].res; satC = gSize[1].sat; end
      2'd2: begin resC = gSize[2].res; satC = gSize[2].sat; end
      default: begin resC = gSize[3].res; satC = gSize[3].sat; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result    <= '0;
      laneSat   <= '0;
      resValid  <= 1'b0;
      resIdx    <= '0;
      done      <= 1'b0;
      stickySat <= 1'b0;
    end else begin
      resValid <= strobe.issue;
      done     <= strobe.issue && strobe.last;
      if (strobe.issue) begin
        result  <= resC;
        laneSat <= satC;
        resIdx  <= strobe.idx;
      end
      if (satClear) stickySat <= 1'b0;
      else if (strobe.issue && (|satC)) stickySat <= 1'b1;
    end
  end

  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    done |-> resValid); // R6
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stickySat && !satClear) |=> stickySat); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    satClear |=> !stickySat); // R8
  AST_FLAG_SETS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && (|laneSat) && !$past(satClear)) |-> stickySat); // R8
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.issue |=> !resValid); // R10
endmodule

// File: rtl/sdmhUnit.sv
module sdmhUnit
  import sdmhPkg::*;
#(
  parameter int W = 128
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           groupCount,
  input  logic [1:0]     sizeSel,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  input  logic           satClear,
  output logic [1:0]     vecIdx,
  output logic           busy,
  output logic [W-1:0]   result,
  output logic [W/8-1:0] laneSat,
  output logic           resValid,
  output logic [1:0]     resIdx,
  output logic           done,
  output logic           stickySat
);
  sdmhStrobe_t strobe;

  sdmhCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .groupCount(groupCount),
    .strobe(strobe), .vecIdx(vecIdx), .busy(busy)
  );

  sdmhLanes #(.W(W)) u_lanes (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sizeSel(sizeSel),
    .opA(opA), .opB(opB), .satClear(satClear),
    .result(result), .laneSat(laneSat), .resValid(resValid),
    .resIdx(resIdx), .done(done), .stickySat(stickySat)
  );
endmodule

// File: tb/sdmhUnit_bench.sv
module sdmhUnit_bench;
  localparam int W = 128;
  logic clk = 0, rstN = 0, start = 0, groupCount = 0, satClear = 0;
  logic [1:0] sizeSel = 0;
  logic [W-1:0] opA = '0, opB = '0;
  logic [1:0] vecIdx, resIdx;
  logic busy, resValid, done, stickySat;
  logic [W-1:0] result;
  logic [W/8-1:0] laneSat;
  int compared = 0, mismatched = 0, cycles = 0;
  logic expSticky = 0;

  sdmhUnit #(.W(W)) u_sdmhUnit (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog act=%0d exp<=100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // behavioural reference: wide signed arithmetic per lane
  function automatic void refVec(input int sz, input logic [W-1:0] a, input logic [W-1:0] b,
                                 output logic [W-1:0] r, output logic [W/8-1:0] f);
    int n = 8 << sz;
    logic signed [129:0] one = 130'sd1;
    logic signed [129:0] mask = (one <<< n) - one;
    logic signed [129:0] maxv = (one <<< (n - 1)) - one;
    logic signed [129:0] ea, eb, p, q;
    logic [129:0] ua, ub, acc;
    acc = '0; f = '0;
    for (int l = 0; l < W / n; l++) begin
      ua = ({2'b0, a} >> (l * n)) & mask;
      ub = ({2'b0, b} >> (l * n)) & mask;
      ea = $signed(ua); if (ua[n-1]) ea = ea - (one <<< n);
      eb = $signed(ub); if (ub[n-1]) eb = eb - (one <<< n);
      p = 130'sd2 * ea * eb;
      q = p >>> n;
      if (q > maxv) begin q = maxv; f[l] = 1'b1; end
      acc = acc | ((q & mask) << (l * n));
    end
    r = acc[W-1:0];
  endfunction

  function automatic logic [W-1:0] fill(input int sz, input int kind);
    int n = 8 << sz;
    logic [W-1:0] v = '0;
    logic [63:0] e;
    for (int l = 0; l < W / n; l++) begin
      case (kind)
        0: e = 64'd1 << (n - 1);                // minimum
        1: e = (64'd1 << (n - 1)) - 64'd1;      // maximum
        2: e = 64'd0;
        default: e = '1;                        // -1
      endcase
      for (int k = 0; k < n; k++) v[l*n + k] = e[k];
    end
    return v;
  endfunction

  task automatic runGroup(input int sz, input logic four, input logic [W-1:0] b,
                          input logic [W-1:0] vs [4], input int clrAt, input logic inject);
    int n = four ? 4 : 2;
    logic [W-1:0] er;
    logic [W/8-1:0] ef;
    @(negedge clk);
    sizeSel = sz[1:0]; groupCount = four; opB = b; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < n; i++) begin
      chk("R5 vecIdx", W'(vecIdx), W'(i));
      opA = vs[i];
      satClear = (clrAt == i);
      start = inject && (i == 1);                     // R7 restart attempt
      @(negedge clk);
      refVec(sz, vs[i], b, er, ef);
      expSticky = (clrAt == i) ? 1'b0 : (expSticky | (|ef));
      chk("R1 R2 R3 result", result, er);
      chk("R3 R4 laneSat", W'(laneSat), W'(ef));
      chk("R5 resValid", W'(resValid), W'(1));
      chk("R5 resIdx", W'(resIdx), W'(i));
      chk("R6 done", W'(done), W'(i == n - 1));
      chk("R8 stickySat", W'(stickySat), W'(expSticky));
    end
    start = 0; satClear = 0;
    @(negedge clk);
    chk("R7 R10 resValid idle", W'(resValid), W'(0));
    chk("R6 done idle", W'(done), W'(0));
    chk("R8 sticky hold", W'(stickySat), W'(expSticky));
  endtask

  initial begin
    logic [W-1:0] vs [4];
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R9 resValid", W'(resValid), W'(0));
    chk("R9 done", W'(done), W'(0));
    chk("R9 stickySat", W'(stickySat), W'(0));
    chk("R9 vecIdx", W'(vecIdx), W'(0));
    @(negedge clk);
    chk("R10 no start", W'(resValid), W'(0));

    for (int sz = 0; sz < 4; sz++) begin
      for (int k = 0; k < 4; k++) vs[k] = fill(sz, k);
      runGroup(sz, 1'b1, fill(sz, 0), vs, -1, 1'b0);  // min x {min,max,0,-1}
      runGroup(sz, 1'b1, fill(sz, 1), vs, -1, 1'b0);  // max x ...
      runGroup(sz, 1'b1, fill(sz, 3), vs, -1, 1'b0);  // -1 x ...
      // R8 clear while idle
      @(negedge clk); satClear = 1;
      @(negedge clk); satClear = 0; expSticky = 0;
      chk("R8 idle clear", W'(stickySat), W'(0));
    end

    // R8 clear in the same cycle as a saturating result
    for (int k = 0; k < 4; k++) vs[k] = fill(1, 0);
    runGroup(1, 1'b1, fill(1, 0), vs, 3, 1'b0);
    // R7 start during a group
    for (int k = 0; k < 4; k++) vs[k] = {$urandom, $urandom, $urandom, $urandom};
    runGroup(2, 1'b1, {$urandom, $urandom, $urandom, $urandom}, vs, -1, 1'b1);
    runGroup(0, 1'b0, {$urandom, $urandom, $urandom, $urandom}, vs, -1, 1'b1);

    // random groups, R1 R2 at every size and both counts
    for (int t = 0; t < 40; t++) begin
      for (int k = 0; k < 4; k++) vs[k] = {$urandom, $urandom, $urandom, $urandom};
      runGroup(t % 4, t[2], {$urandom, $urandom, $urandom, $urandom}, vs, -1, 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule